// File: doc/BRIEF.md
# PHY-to-Link Status and Receive Sender

This block is the PHY-side transmitter of a narrow PHY-to-link interface that uses a two-bit control pair and a two-bit data pair. Each clock it presents one 2-bit symbol. While the PHY owns the interface, the control pair tells the link what the data pair carries. Code 00 means the interface is idle. Code 01 marks a status transfer. Code 10 marks a packet being received. Code 11, the transmit grant, belongs to logic outside this block, and this block never drives it.

Two kinds of traffic share the pair. The first is status transfers. A short transfer carries four flags. A full transfer carries a sixteen-bit image: the flags, a register address and the register contents. The second is received packets. These arrive from the line decoder two bits per cycle and enter a small buffer. They go out behind a marker cycle and a speed-code cycle. Packet reception always wins. It can interrupt a status transfer that is under way. The interrupted status is kept and sent again from its first symbol once the packet is finished.

Top module: `phy_link_sender`

## Requirements
- R1: While reset is high, and in the first cycle after it, both the control pair and the data pair read 00.
- R2: The control pair only ever shows 00 (idle), 01 (status) or 10 (receive). It never shows 11.
- R3: A status transfer starts only in the cycle after one in which the control pair was 00. Back-to-back transfers are therefore separated by exactly one idle cycle. When the interface is idle, the first status symbol appears two cycles after the request cycle.
- R4: A short status transfer has two symbols with control 01. Status bit 0 is arbitration-reset-gap, bit 1 is subaction-gap, bit 2 is bus-reset and bit 3 is cable-power-low, taken from `stat_flags[0..3]`. Symbol k carries status bit 2k on data line 0 and status bit 2k+1 on data line 1.
- R5: A full status transfer has eight symbols with control 01 and the same bit-to-line mapping as R4. Status bits 4 to 7 hold the register address, most significant bit first (bit 4 = `reg_addr[3]`). Status bits 8 to 15 hold the register data, most significant bit first (bit 8 = `reg_data[7]`).
- R6: A received packet goes out as follows. First comes a marker cycle with control 10 and data 11. Next comes a cycle with control 10 and data equal to the speed code (00 by default). Then each accepted symbol follows with control 10, where `rx_data[0]` goes on line 0. The control pair returns to 00 in the cycle after the symbol flagged last. The marker appears two cycles after the first symbol is accepted. No symbol is lost or reordered.
- R7: Receive has priority over status. A pending status waits while a packet is sent. If packet data arrives during a status transfer, that transfer stops before its next symbol. It is then sent again in full, starting one idle cycle after the packet ends.
- R8: A status request stays latched, with the contents captured at request time, until its final symbol has been sent. Any request made while one is pending is ignored and produces no transfer.
- R9: If a short request and a full request arrive in the same cycle, a single full transfer is sent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Interface clock |
| rst | input | 1 | Synchronous active-high reset |
| stat_req | input | 1 | One-cycle request for a short status transfer |
| reg_req | input | 1 | One-cycle request for a full status transfer |
| stat_flags | input | 4 | Status flags, bit 0 first on the wire |
| reg_addr | input | 4 | Register address for a full transfer |
| reg_data | input | 8 | Register contents for a full transfer |
| rx_valid | input | 1 | Received symbol present this cycle |
| rx_data | input | 2 | Received 2-bit symbol |
| rx_last | input | 1 | Marks the final symbol of a packet |
| ctl | output | 2 | Control pair to the link (registered) |
| dat | output | 2 | Data pair to the link (registered) |

## Verification
The embedded assertions check, on every cycle, that the transmit-grant code is never driven and that a status run always begins after an idle cycle. They also check that every receive run opens with the marker, that a latched request and its contents stay still until the final symbol has been sent, and that the packet buffer neither overflows nor is read while empty. Some properties can only be shown by the bench's directed scenarios, because each needs the exact symbol sequence compared against a stream built from the requirements. These are the bit order and field placement of short and full transfers, the placement of the speed code, the rule that a full request wins over a short one, the silence after an ignored request, and the full restart of a transfer pre-empted by a packet.

// File: rtl/plk_pkg.sv
package plk_pkg;

  // Meaning of the control pair while the PHY owns the interface
  typedef enum logic [1:0] {
    CTL_IDLE = 2'b00,
    CTL_STAT = 2'b01,
    CTL_RECV = 2'b10,
    CTL_XMIT = 2'b11
  } ctl_e;

  // What the registered output currently shows
  typedef enum logic [2:0] {
    M_IDLE,   // idle symbol on the pair
    M_STAT,   // a status symbol
    M_MARK,   // receive marker
    M_DATA,   // speed code or packet symbol, more to come
    M_TAIL    // final packet symbol
  } mode_e;

endpackage

// File: rtl/plk_rx_fifo.sv
module plk_rx_fifo #(
  parameter int DW    = 3,
  parameter int DEPTH = 8   // power of two
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          push,
  input  logic [DW-1:0] wdata,
  input  logic          pop,
  output logic [DW-1:0] rdata,
  output logic          empty,
  output logic          full
);
  localparam int AW = $clog2(DEPTH);
  localparam int CW = AW + 1;

  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic [CW-1:0] cnt;
  logic          do_push, do_pop;

  assign empty   = (cnt == '0);
  assign full    = (cnt == CW'(DEPTH));
  assign do_push = push && !full;
  assign do_pop  = pop && !empty;
  assign rdata   = mem[rp];

  // Storage without reset so it maps onto distributed RAM
  always_ff @(posedge clk) begin
    if (do_push) mem[wp] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
    end else begin
      if (do_push) wp <= wp + 1'b1;
      if (do_pop)  rp <= rp + 1'b1;
      case ({do_push, do_pop})
        2'b10:   cnt <= cnt + 1'b1;
        2'b01:   cnt <= cnt - 1'b1;
        default: cnt <= cnt;
      endcase
    end
  end

  // R6: no received symbol may be dropped
  a_r6_no_overflow: assert property (@(posedge clk) disable iff (rst)
    push |-> !full);

  // R6: the scheduler only reads symbols that exist
  a_r6_no_underflow: assert property (@(posedge clk) disable iff (rst)
    pop |-> !empty);

endmodule

// File: rtl/plk_stat_hold.sv
module plk_stat_hold #(
  parameter int FLAG_W = 4,
  parameter int ADDR_W = 4,
  parameter int DATA_W = 8
) (
  input  logic                              clk,
  input  logic                              rst,
  input  logic                              req_short,
  input  logic                              req_full,
  input  logic [FLAG_W-1:0]                 flags,
  input  logic [ADDR_W-1:0]                 addr,
  input  logic [DATA_W-1:0]                 data,
  input  logic                              clr,
  output logic                              pend,
  output logic                              full,
  output logic [FLAG_W+ADDR_W+DATA_W-1:0]   word
);
  localparam int WORD_W = FLAG_W + ADDR_W + DATA_W;

  logic [WORD_W-1:0] nword;

  // Word bit i is status bit i; address and data go MSB first
  always_comb begin
    nword = '0;
    nword[FLAG_W-1:0] = flags;
    if (req_full) begin
      for (int i = 0; i < ADDR_W; i++)
        nword[FLAG_W+i] = addr[ADDR_W-1-i];
      for (int i = 0; i < DATA_W; i++)
        nword[FLAG_W+ADDR_W+i] = data[DATA_W-1-i];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pend <= 1'b0;
      full <= 1'b0;
      word <= '0;
    end else if (pend) begin
      if (clr) pend <= 1'b0;
    end else if (req_short || req_full) begin
      pend <= 1'b1;
      full <= req_full;
      word <= nword;
    end
  end

  // R8: a latched request and its contents hold until the last symbol
  a_r8_hold_until_sent: assert property (@(posedge clk) disable iff (rst)
    (pend && !clr) |=> (pend && $stable(word) && $stable(full)));

endmodule

// File: rtl/plk_out_sched.sv
module plk_out_sched
  import plk_pkg::*;
#(
  parameter int         WORD_W     = 16,
  parameter int         SHORT_W    = 4,
  parameter logic [1:0] SPEED_CODE = 2'b00
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rx_empty,
  input  logic [1:0]        rx_sym,
  input  logic              rx_last,
  output logic              rx_pop,
  input  logic              pend,
  input  logic              full,
  input  logic [WORD_W-1:0] word,
  output logic              stat_clr,
  output logic [1:0]        ctl_o,
  output logic [1:0]        dat_o
);
  localparam int FULL_SYM  = WORD_W / 2;
  localparam int SHORT_SYM = SHORT_W / 2;
  localparam int IW        = $clog2(FULL_SYM + 1);

  mode_e         mode, nmode;
  ctl_e          ctl_q, nctl;
  logic [1:0]    dat_q, ndat;
  logic [IW-1:0] idx, nidx, nsym;

  assign nsym = full ? IW'(FULL_SYM) : IW'(SHORT_SYM);

  always_comb begin
    nmode    = mode;
    nctl     = CTL_IDLE;
    ndat     = 2'b00;
    nidx     = idx;
    rx_pop   = 1'b0;
    stat_clr = 1'b0;
    case (mode)
      M_IDLE: begin
        if (!rx_empty) begin
          nctl  = CTL_RECV;
          ndat  = 2'b11;
          nmode = M_MARK;
        end else if (pend) begin
          nctl  = CTL_STAT;
          ndat  = word[1:0];
          nidx  = IW'(1);
          nmode = M_STAT;
        end
      end
      M_STAT: begin
        if (idx == nsym || !rx_empty) begin
          // finished, or pre-empted by packet data
          nidx = '0;
          if (!rx_empty) begin
            nctl  = CTL_RECV;
            ndat  = 2'b11;
            nmode = M_MARK;
          end else begin
            nmode = M_IDLE;
          end
        end else begin
          nctl = CTL_STAT;
          ndat = word[{idx, 1'b0} +: 2];
          nidx = idx + 1'b1;
          if (idx == nsym - 1'b1) stat_clr = 1'b1;
        end
      end
      M_MARK: begin
        nctl  = CTL_RECV;
        ndat  = SPEED_CODE;
        nmode = M_DATA;
      end
      M_DATA: begin
        if (rx_empty) begin
          nmode = M_IDLE;
        end else begin
          rx_pop = 1'b1;
          nctl   = CTL_RECV;
          ndat   = rx_sym;
          nmode  = rx_last ? M_TAIL : M_DATA;
        end
      end
      default: begin
        nmode = M_IDLE;   // M_TAIL: one idle cycle after a packet
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mode  <= M_IDLE;
      ctl_q <= CTL_IDLE;
      dat_q <= 2'b00;
      idx   <= '0;
    end else begin
      mode  <= nmode;
      ctl_q <= nctl;
      dat_q <= ndat;
      idx   <= nidx;
    end
  end

  assign ctl_o = ctl_q;
  assign dat_o = dat_q;

  // R2: the transmit-grant code is never produced here
  a_r2_no_grant: assert property (@(posedge clk) disable iff (rst)
    ctl_q != CTL_XMIT);

  // R3: a status run always follows an idle cycle
  a_r3_status_after_idle: assert property (@(posedge clk) disable iff (rst)
    (ctl_q == CTL_STAT && $past(ctl_q) != CTL_STAT) |-> $past(ctl_q) == CTL_IDLE);

  // R6: every receive run opens with the marker symbol
  a_r6_marker_first: assert property (@(posedge clk) disable iff (rst)
    (ctl_q == CTL_RECV && $past(ctl_q) != CTL_RECV) |-> dat_q == 2'b11);

endmodule

// File: rtl/phy_link_sender.sv
module phy_link_sender #(
  parameter int         FLAG_W     = 4,
  parameter int         ADDR_W     = 4,
  parameter int         DATA_W     = 8,
  parameter int         RX_DEPTH   = 8,
  parameter logic [1:0] SPEED_CODE = 2'b00
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              stat_req,
  input  logic              reg_req,
  input  logic [FLAG_W-1:0] stat_flags,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_data,
  input  logic              rx_valid,
  input  logic [1:0]        rx_data,
  input  logic              rx_last,
  output logic [1:0]        ctl,
  output logic [1:0]        dat
);
  localparam int WORD_W = FLAG_W + ADDR_W + DATA_W;
  localparam int RX_W   = 3;

  logic              fifo_empty, fifo_full, fifo_pop;
  logic [RX_W-1:0]   fifo_rd;
  logic              pend, full, stat_clr;
  logic [WORD_W-1:0] word;

  plk_rx_fifo #(.DW(RX_W), .DEPTH(RX_DEPTH)) u_fifo (
    .clk   (clk),
    .rst   (rst),
    .push  (rx_valid),
    .wdata ({rx_last, rx_data}),
    .pop   (fifo_pop),
    .rdata (fifo_rd),
    .empty (fifo_empty),
    .full  (fifo_full)
  );

  plk_stat_hold #(.FLAG_W(FLAG_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_hold (
    .clk       (clk),
    .rst       (rst),
    .req_short (stat_req),
    .req_full  (reg_req),
    .flags     (stat_flags),
    .addr      (reg_addr),
    .data      (reg_data),
    .clr       (stat_clr),
    .pend      (pend),
    .full      (full),
    .word      (word)
  );

  plk_out_sched #(.WORD_W(WORD_W), .SHORT_W(FLAG_W), .SPEED_CODE(SPEED_CODE)) u_sched (
    .clk      (clk),
    .rst      (rst),
    .rx_empty (fifo_empty),
    .rx_sym   (fifo_rd[1:0]),
    .rx_last  (fifo_rd[2]),
    .rx_pop   (fifo_pop),
    .pend     (pend),
    .full     (full),
    .word     (word),
    .stat_clr (stat_clr),
    .ctl_o    (ctl),
    .dat_o    (dat)
  );

  // R6: the source must never push into a full buffer
  a_r6_buffer_room: assert property (@(posedge clk) disable iff (rst)
    rx_valid |-> !fifo_full);

endmodule

// File: tb/phy_link_sender_bench.sv
module phy_link_sender_bench;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       stat_req = 1'b0, reg_req = 1'b0;
  logic [3:0] stat_flags = '0, reg_addr = '0;
  logic [7:0] reg_data = '0;
  logic       rx_valid = 1'b0, rx_last = 1'b0;
  logic [1:0] rx_data = '0;
  logic [1:0] ctl, dat;

  int n_run = 0, n_fail = 0;

  // per-cycle stimulus and expectation, index = negedge count
  logic       st_s [0:63];
  logic       st_f [0:63];
  logic [3:0] fl   [0:63];
  logic [3:0] ad   [0:63];
  logic [7:0] dt   [0:63];
  logic       rv   [0:63];
  logic [1:0] rd   [0:63];
  logic       rl   [0:63];
  logic [3:0] ex   [0:63];

  always #10 clk = ~clk;   // 50 MHz

  phy_link_sender u_phy_link_sender (
    .clk(clk), .rst(rst), .stat_req(stat_req), .reg_req(reg_req),
    .stat_flags(stat_flags), .reg_addr(reg_addr), .reg_data(reg_data),
    .rx_valid(rx_valid), .rx_data(rx_data), .rx_last(rx_last),
    .ctl(ctl), .dat(dat)
  );

  task automatic check(input string tag, input int c, input logic [3:0] got, input logic [3:0] exp);
    n_run++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s cycle %0d: {ctl,dat} got %b expected %b", tag, c, got, exp);
    end
  endtask

  task automatic clear_plan();
    for (int i = 0; i < 64; i++) begin
      st_s[i] = 0; st_f[i] = 0; fl[i] = '0; ad[i] = '0; dt[i] = '0;
      rv[i] = 0; rd[i] = '0; rl[i] = 0; ex[i] = 4'b0000;
    end
  endtask

  // expected status symbols per R4/R5
  task automatic exp_status(input int at, input bit isfull, input logic [3:0] f,
                            input logic [3:0] a, input logic [7:0] d);
    logic [15:0] s;
    int nsym;
    s = '0;
    s[3:0] = f;
    if (isfull) begin
      for (int i = 0; i < 4; i++) s[4+i] = a[3-i];
      for (int i = 0; i < 8; i++) s[8+i] = d[7-i];
    end
    nsym = isfull ? 8 : 2;
    for (int k = 0; k < nsym; k++) ex[at+k] = {2'b01, s[2*k+1], s[2*k]};
  endtask

  // packet stimulus at cycles at..at+len-1
  task automatic put_rx(input int at, input int len, input int seed);
    for (int k = 0; k < len; k++) begin
      rv[at+k] = 1;
      rd[at+k] = 2'((k + seed) % 4);
      rl[at+k] = (k == len - 1);
    end
  endtask

  // expected receive framing per R6: marker two cycles after first symbol
  task automatic exp_rx(input int rs, input int len);
    ex[rs+2] = 4'b1011;
    ex[rs+3] = 4'b1000;
    for (int k = 0; k < len; k++) ex[rs+4+k] = {2'b10, rd[rs+k]};
  endtask

  task automatic play(input int n, input string tag);
    for (int c = 0; c < n; c++) begin
      stat_req = st_s[c]; reg_req = st_f[c];
      stat_flags = fl[c]; reg_addr = ad[c]; reg_data = dt[c];
      rx_valid = rv[c]; rx_data = rd[c]; rx_last = rl[c];
      check(tag, c, {ctl, dat}, ex[c]);
      @(negedge clk);
    end
    stat_req = 0; reg_req = 0; rx_valid = 0; rx_last = 0;
    repeat (3) @(negedge clk);
  endtask

  task automatic t_reset();
    check("R1 in reset", 0, {ctl, dat}, 4'b0000);
    rst = 1'b0;
    @(negedge clk);
    check("R1 after reset", 1, {ctl, dat}, 4'b0000);
  endtask

  task automatic t_short();
    clear_plan();
    st_s[0] = 1; fl[0] = 4'b1011;
    exp_status(2, 0, 4'b1011, 4'h0, 8'h00);
    play(8, "R4 short status");
  endtask

  task automatic t_full();
    clear_plan();
    st_f[0] = 1; fl[0] = 4'b0110; ad[0] = 4'hA; dt[0] = 8'hC5;
    exp_status(2, 1, 4'b0110, 4'hA, 8'hC5);
    play(14, "R5 full status");
  endtask

  task automatic t_gap();
    clear_plan();
    st_s[0] = 1; fl[0] = 4'b0101;
    st_s[3] = 1; fl[3] = 4'b1110;
    exp_status(2, 0, 4'b0101, 4'h0, 8'h00);
    exp_status(5, 0, 4'b1110, 4'h0, 8'h00);   // one idle at cycle 4
    play(10, "R3 idle gap");
  endtask

  task automatic t_ignore();
    clear_plan();
    st_f[0] = 1; fl[0] = 4'b1001; ad[0] = 4'h3; dt[0] = 8'h5A;
    st_s[2] = 1; fl[2] = 4'b0110;
    st_f[5] = 1; fl[5] = 4'b1111; ad[5] = 4'hF; dt[5] = 8'hFF;
    exp_status(2, 1, 4'b1001, 4'h3, 8'h5A);
    play(18, "R8 request while pending");
  endtask

  task automatic t_both();
    clear_plan();
    st_s[0] = 1; st_f[0] = 1; fl[0] = 4'b0011; ad[0] = 4'h6; dt[0] = 8'h81;
    exp_status(2, 1, 4'b0011, 4'h6, 8'h81);
    play(14, "R9 full wins");
  endtask

  task automatic t_rx();
    clear_plan();
    put_rx(0, 5, 1);
    exp_rx(0, 5);
    play(12, "R6 receive framing");
  endtask

  task automatic t_rx_prio();
    clear_plan();
    st_s[0] = 1; fl[0] = 4'b1100;
    put_rx(0, 3, 2);
    exp_rx(0, 3);
    exp_status(8, 0, 4'b1100, 4'h0, 8'h00);
    play(13, "R7 receive before pending status");
  endtask

  task automatic t_preempt();
    clear_plan();
    st_f[0] = 1; fl[0] = 4'b1010; ad[0] = 4'h9; dt[0] = 8'h3C;
    exp_status(2, 1, 4'b1010, 4'h9, 8'h3C);
    for (int i = 5; i < 10; i++) ex[i] = 4'b0000;
    put_rx(3, 3, 0);
    exp_rx(3, 3);
    exp_status(11, 1, 4'b1010, 4'h9, 8'h3C);
    play(21, "R7 pre-empt and retry");
  endtask

  task automatic t_rx_back();
    clear_plan();
    put_rx(0, 2, 3);
    put_rx(8, 4, 1);
    exp_rx(0, 2);
    exp_rx(8, 4);
    play(18, "R6 second packet, R2 codes");
  endtask

  initial begin
    #2_000_000;
    n_fail++;
    $display("FAIL watchdog: run did not finish, got hang expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    repeat (2) @(negedge clk);
    t_short();
    t_full();
    t_gap();
    t_ignore();
    t_both();
    t_rx();
    t_rx_prio();
    t_preempt();
    t_rx_back();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule